// File: doc/BRIEF.md
# Idle Screen Dimmer and Blanker

This block is a screen saver for a character display. It counts vertical-sync pulses while the keyboard is idle. When a programmable number of frames has passed with no key activity, it starts to dim the display. It raises the brightness code by one step each time a programmable number of frames passes, until it reaches the dimmest code. At that point it blanks the screen by replacing the first-line pointer with a fixed pointer to a blank line.

Any key activity returns the block to its idle-counting state. On the next cycle it presents the brightness and first-line pointer that were in effect before the saver took over.

When the saver is idle, the outputs follow the configured brightness and pointer inputs with one register of delay. While the saver is active, the block drives the outputs itself.

Top module: `frame_dimmer`

## Requirements
- R1: A synchronous reset, with `rst` high at a clock edge, sets `saver_state` to 0. From the first edge after reset, `bright_out` and `line_ptr_out` equal the values `bright_in` and `line_ptr_in` had at the previous edge.
- R2: `saver_state` uses the encoding 0 = idle, 1 = fading, 2 = blanked. The value 3 never appears. While the state is 0, the outputs follow the inputs with one cycle of delay.
- R3: Fading begins, with state 1, on the edge that samples the N-th `vsync_pulse` counted since reset or since the last `key_hit`. N is `idle_frames`, and a value of 0 acts as 1. Cycles where `vsync_pulse` is low do not advance any count.
- R4: Brightness code 0 is brightest and 31 is dimmest. On entry to fading, the `bright_in` value is saved and appears on `bright_out`.
- R5: While fading, `bright_out` rises by exactly 1 on every M-th `vsync_pulse`, and holds otherwise. M is `step_frames`, and a value of 0 acts as 1.
- R6: On the edge where the code reaches 31, the state becomes 2. On that edge `line_ptr_in` is saved and `line_ptr_out` becomes 0x0370. If `bright_in` is already 31 when the timeout expires, the block goes straight from state 0 to state 2.
- R7: In state 2 the block ignores `bright_in`, `line_ptr_in` and `vsync_pulse`. The outputs stay at 31 and 0x0370.
- R8: A `key_hit` in state 1 or 2 sets state 0 on the next edge. On that edge `bright_out` shows the saved brightness. `line_ptr_out` shows the saved pointer if the state was 2, or `line_ptr_in` if the state was 1. From the following edge on, the outputs follow the inputs again.
- R9: A `key_hit` in any state reloads the idle count. It takes priority over a `vsync_pulse` in the same cycle, so that pulse is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vsync_pulse | input | 1 | One-cycle strobe per vertical frame |
| key_hit | input | 1 | One-cycle strobe on keyboard activity |
| idle_frames | input | 16 | Frames of inactivity before fading starts |
| step_frames | input | 8 | Frames between brightness steps |
| bright_in | input | 5 | Configured brightness code |
| line_ptr_in | input | 16 | Normal first-line pointer |
| bright_out | output | 5 | Brightness code to the D/A converter |
| line_ptr_out | output | 16 | First-line pointer to the display fetch |
| saver_state | output | 2 | 0 idle, 1 fading, 2 blanked |

## Verification
The hardest situation to reach is a wake from the blanked state in which the saved values differ from the current inputs. Only that case shows that the restore uses the stored copies rather than the live inputs. To reach it, the bench runs each trial until the block is blanked. It then changes `bright_in` and `line_ptr_in` and raises `key_hit`. The bench expects the old values for exactly one cycle and the new values after that. Random idle times, step lengths, starting codes and gaps between pulses drive the block through every fade length, including a start at the dimmest code.

// File: rtl/frame_dimmer.sv
module frame_dimmer #(
  parameter int BW = 5,
  parameter int PW = 16,
  parameter int IW = 16,
  parameter int SW = 8,
  parameter logic [PW-1:0] BLANK_PTR = 16'h0370
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vsync_pulse,
  input  logic          key_hit,
  input  logic [IW-1:0] idle_frames,
  input  logic [SW-1:0] step_frames,
  input  logic [BW-1:0] bright_in,
  input  logic [PW-1:0] line_ptr_in,
  output logic [BW-1:0] bright_out,
  output logic [PW-1:0] line_ptr_out,
  output logic [1:0]    saver_state
);
  localparam logic [BW-1:0] DIMMEST  = '1;
  localparam logic [1:0]    ST_IDLE  = 2'd0;
  localparam logic [1:0]    ST_FADE  = 2'd1;
  localparam logic [1:0]    ST_BLANK = 2'd2;

  logic [1:0]    state;
  logic [IW-1:0] idle_cnt;
  logic [SW-1:0] step_cnt;
  logic [BW-1:0] bright_q, bright_sav;
  logic [PW-1:0] ptr_q, ptr_sav;
  logic [BW-1:0] bright_nx;

  assign bright_nx    = bright_q + 1'b1;
  assign bright_out   = bright_q;
  assign line_ptr_out = ptr_q;
  assign saver_state  = state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      idle_cnt   <= idle_frames;
      step_cnt   <= step_frames;
      bright_q   <= bright_in;
      ptr_q      <= line_ptr_in;
      bright_sav <= bright_in;
      ptr_sav    <= line_ptr_in;
    end else if (key_hit) begin
      state    <= ST_IDLE;
      idle_cnt <= idle_frames;
      step_cnt <= step_frames;
      bright_q <= (state == ST_IDLE) ? bright_in : bright_sav;
      ptr_q    <= (state == ST_BLANK) ? ptr_sav : line_ptr_in;
    end else begin
      case (state)
        ST_IDLE: begin
          bright_q <= bright_in;
          ptr_q    <= line_ptr_in;
          if (vsync_pulse) begin
            if (idle_cnt <= IW'(1)) begin
              bright_sav <= bright_in;
              step_cnt   <= step_frames;
              if (bright_in == DIMMEST) begin
                state   <= ST_BLANK;
                ptr_sav <= line_ptr_in;
                ptr_q   <= BLANK_PTR;
              end else begin
                state <= ST_FADE;
              end
            end else begin
              idle_cnt <= idle_cnt - 1'b1;
            end
          end
        end
        ST_FADE: begin
          ptr_q <= line_ptr_in;
          if (vsync_pulse) begin
            if (step_cnt <= SW'(1)) begin
              step_cnt <= step_frames;
              bright_q <= bright_nx;
              if (bright_nx == DIMMEST) begin
                state   <= ST_BLANK;
                ptr_sav <= line_ptr_in;
                ptr_q   <= BLANK_PTR;
              end
            end else begin
              step_cnt <= step_cnt - 1'b1;
            end
          end
        end
        ST_BLANK: ;
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r2_state_legal: assert property (@(posedge clk) disable iff (rst)
    state != 2'd3);

  a_r3_no_count_without_pulse: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !vsync_pulse) |=> state == ST_IDLE);

  a_r5_hold_between_pulses: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FADE && !key_hit && !vsync_pulse) |=> $stable(bright_q));

  a_r5_single_step: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FADE && !key_hit && vsync_pulse) |=>
      (bright_q == $past(bright_q) || bright_q == $past(bright_q) + 1'b1));

  a_r7_blank_outputs: assert property (@(posedge clk) disable iff (rst)
    state == ST_BLANK |-> (ptr_q == BLANK_PTR && bright_q == DIMMEST));

  a_r8_wake_restore: assert property (@(posedge clk) disable iff (rst)
    (key_hit && state == ST_BLANK) |=>
      (state == ST_IDLE && ptr_q == $past(ptr_sav) && bright_q == $past(bright_sav)));

  a_r9_key_priority: assert property (@(posedge clk) disable iff (rst)
    key_hit |=> state == ST_IDLE);
endmodule

// File: tb/test_frame_dimmer.sv
module test_frame_dimmer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vsync_pulse = 1'b0;
  logic        key_hit = 1'b0;
  logic [15:0] idle_frames = 16'd4;
  logic [7:0]  step_frames = 8'd2;
  logic [4:0]  bright_in = 5'd3;
  logic [15:0] line_ptr_in = 16'h1234;
  logic [4:0]  bright_out;
  logic [15:0] line_ptr_out;
  logic [1:0]  saver_state;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_dimmer i_frame_dimmer (
    .clk(clk), .rst(rst), .vsync_pulse(vsync_pulse), .key_hit(key_hit),
    .idle_frames(idle_frames), .step_frames(step_frames),
    .bright_in(bright_in), .line_ptr_in(line_ptr_in),
    .bright_out(bright_out), .line_ptr_out(line_ptr_out),
    .saver_state(saver_state)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int exp_bright(input int n, input int i, input int s, input int b0);
    int b;
    if (n < eff(i)) return b0;
    b = b0 + (n - eff(i)) / eff(s);
    return (b > 31) ? 31 : b;
  endfunction

  function automatic int exp_state(input int n, input int i, input int s, input int b0);
    if (n < eff(i)) return 0;
    if (exp_bright(n, i, s, b0) == 31) return 2;
    return 1;
  endfunction

  task automatic idle_cycles(input int k);
    for (int c = 0; c < k; c++) @(negedge clk);
  endtask

  task automatic pulse_vs;
    @(negedge clk) vsync_pulse = 1'b1;
    @(negedge clk) vsync_pulse = 1'b0;
  endtask

  task automatic pulse_key;
    @(negedge clk) key_hit = 1'b1;
    @(negedge clk) key_hit = 1'b0;
  endtask

  task automatic run_trial(input int i, input int s, input int b0, input logic [15:0] p0);
    int n;
    logic [15:0] pn;
    @(negedge clk);
    idle_frames = 16'(i); step_frames = 8'(s); bright_in = 5'(b0); line_ptr_in = p0;
    pulse_key();
    @(negedge clk);
    chk("R2 idle follows bright", int'(bright_out), b0);
    n = 0;
    while (exp_state(n, i, s, b0) != 2) begin
      pulse_vs();
      n++;
      chk("R3/R4/R5 state", int'(saver_state), exp_state(n, i, s, b0));
      chk("R4/R5 brightness", int'(bright_out), exp_bright(n, i, s, b0));
      idle_cycles($urandom_range(0, 3));
    end
    chk("R6 blank pointer", int'(line_ptr_out), 16'h0370);
    bright_in = 5'(b0 ^ 5'h0A);
    pn = p0 ^ 16'h5A5A;
    line_ptr_in = pn;
    pulse_vs();
    idle_cycles(2);
    chk("R7 ignored bright", int'(bright_out), 31);
    chk("R7 ignored pointer", int'(line_ptr_out), 16'h0370);
    chk("R7 stays blank", int'(saver_state), 2);
    @(negedge clk) key_hit = 1'b1;
    @(negedge clk) key_hit = 1'b0;
    chk("R8 wake state", int'(saver_state), 0);
    chk("R8 restored bright", int'(bright_out), b0);
    chk("R8 restored pointer", int'(line_ptr_out), int'(p0));
    @(negedge clk);
    chk("R8 then follows bright", int'(bright_out), int'(b0 ^ 5'h0A) & 31);
    chk("R8 then follows pointer", int'(line_ptr_out), int'(pn));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset state", int'(saver_state), 0);
    chk("R1 reset bright", int'(bright_out), 3);
    chk("R1 reset pointer", int'(line_ptr_out), 16'h1234);
    bright_in = 5'd7; line_ptr_in = 16'h2222;
    @(negedge clk);
    chk("R2 follow bright", int'(bright_out), 7);
    chk("R2 follow pointer", int'(line_ptr_out), 16'h2222);

    run_trial(0, 0, 29, 16'h22D0);
    run_trial(3, 2, 31, 16'h4321);
    run_trial(1, 1, 0, 16'h0ABC);

    // R8 wake from fading
    @(negedge clk);
    idle_frames = 16'd2; step_frames = 8'd3; bright_in = 5'd10; line_ptr_in = 16'h3000;
    pulse_key();
    pulse_vs(); pulse_vs(); pulse_vs(); pulse_vs(); pulse_vs();
    chk("R5 mid fade state", int'(saver_state), 1);
    chk("R5 mid fade bright", int'(bright_out), 11);
    line_ptr_in = 16'h3333;
    @(negedge clk);
    chk("R8 fade pointer follows", int'(line_ptr_out), 16'h3333);
    bright_in = 5'd2;
    @(negedge clk) key_hit = 1'b1;
    @(negedge clk) key_hit = 1'b0;
    chk("R8 fade wake state", int'(saver_state), 0);
    chk("R8 fade wake bright", int'(bright_out), 10);
    chk("R8 fade wake pointer", int'(line_ptr_out), 16'h3333);

    // R9 key reloads idle count and beats a same-cycle vsync
    bright_in = 5'd10;
    idle_frames = 16'd4;
    pulse_key();
    pulse_vs(); pulse_vs(); pulse_vs();
    chk("R9 not yet fading", int'(saver_state), 0);
    @(negedge clk) begin key_hit = 1'b1; vsync_pulse = 1'b1; end
    @(negedge clk) begin key_hit = 1'b0; vsync_pulse = 1'b0; end
    chk("R9 key beats vsync", int'(saver_state), 0);
    pulse_vs(); pulse_vs(); pulse_vs();
    chk("R9 reloaded count", int'(saver_state), 0);
    pulse_vs();
    chk("R3 timeout after reload", int'(saver_state), 1);

    for (int t = 0; t < 8; t++)
      run_trial($urandom_range(0, 20), $urandom_range(0, 6), $urandom_range(0, 31),
                16'($urandom));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule